// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block holds the two registers a PC-style serial port uses for modem handshaking. The host writes a control byte that sets the outgoing handshake lines (terminal ready, request to send, one general-purpose output) and an interrupt-output enable. The host reads a status byte that gives the present level of the four incoming handshake lines (clear to send, data set ready, ring, carrier detect). The same byte carries four sticky change flags that record what has happened on those lines since the last status read.

The incoming lines are asynchronous. Each one passes through a synchronizer before edge detection. The change flags for clear to send, data set ready and carrier detect set on either edge. The ring flag sets only when the ring line goes from asserted to deasserted. A status read clears all four flags. The OR of the flags is brought out as the modem-status interrupt cause.

A diagnostic loopback mode routes the control bits internally back onto the status inputs and forces the external outgoing lines inactive. Software can then exercise the whole status path without a modem. Edge tracking is run by a two-state controller:
- After reset it sits in `ST_SETTLE` for `SYNC_STAGES+1` cycles while the synchronizers fill. No change flags are recorded in this state.
- It then moves to `ST_TRACK` and stays there until the next reset.

Top module: `mdm_ctl_stat`

## Requirements
- R1: A write with `host_addr`=0 stores `host_wdata[4:0]` as the control byte. A read with `host_addr`=0 returns that value in bits 4:0 and zeros in bits 7:5. Control bit fields are: bit0 terminal ready, bit1 request to send, bit2 general output, bit3 interrupt-output enable, bit4 loopback.
- R2: While bit4 of the control byte is 0, `dtr_o`, `rts_o` and `out1_o` follow control bits 0, 1 and 2 from the cycle after the write. `irq_en_o` follows control bit3 in every mode.
- R3: A status read (`host_addr`=1) returns the current line levels in bits 7:4: bit4 clear to send, bit5 data set ready, bit6 ring, bit7 carrier detect. An external input change reaches these bits two clock edges after it is applied.
- R4: Status bits 0, 1 and 3 set when the clear-to-send, data-set-ready and carrier-detect level (respectively) changes in either direction. With external inputs, the flag is visible on the third clock edge after the input changes.
- R5: Status bit2 sets only on a 1-to-0 transition of the ring level. A 0-to-1 transition leaves it clear.
- R6: The change flags remain set until a status read. The clock edge that ends a status read clears all four flags. A change detected on that same edge still sets its flag.
- R7: `msi_o` is high exactly while at least one change flag is set.
- R8: In loopback mode the levels are taken internally:
  - request to send drives clear to send;
  - terminal ready drives data set ready;
  - the general output drives ring;
  - the interrupt-output enable drives carrier detect.
  
  `dtr_o`, `rts_o` and `out1_o` are held at 0, and the external inputs have no effect on the status byte.
- R9: For `SYNC_STAGES+1` cycles after reset (`ST_SETTLE`), no change flag is set. An input held high through reset therefore shows as a level only.
- R10: After reset the control byte, the outputs and the change flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 1 | Register select: 0 control, 1 status |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; on status it clears the change flags |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| cts_i | input | 1 | External clear-to-send input, asynchronous |
| dsr_i | input | 1 | External data-set-ready input, asynchronous |
| ri_i | input | 1 | External ring input, asynchronous |
| dcd_i | input | 1 | External carrier-detect input, asynchronous |
| dtr_o | output | 1 | Terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General-purpose output |
| irq_en_o | output | 1 | Interrupt-output enable |
| msi_o | output | 1 | Modem-status interrupt cause |

## Verification
The hardest case to reach is a ring trailing edge detected on the exact clock edge that ends a status read. This is where the clear and the new flag collide. External inputs cross a synchronizer, so their edge timing is awkward to line up from outside. The bench therefore uses loopback: it clears the general-output control bit with a write and presents a status read in the very next cycle, which places the detected edge on the read's closing clock edge. A second read then shows whether the flag survived.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    // Line index order shared by level and change-flag fields.
    localparam int LINE_N  = 4;
    localparam int LN_CTS  = 0;
    localparam int LN_DSR  = 1;
    localparam int LN_RI   = 2;
    localparam int LN_DCD  = 3;

    // Control byte fields.
    localparam int CTL_W    = 5;
    localparam int CB_DTR   = 0;
    localparam int CB_RTS   = 1;
    localparam int CB_OUT1  = 2;
    localparam int CB_IRQEN = 3;
    localparam int CB_LOOP  = 4;

    localparam logic ADDR_CTL  = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_TRACK  = 1'b1
    } trk_state_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[gi]};
            end
            assign sync_o[gi] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTL_W-1:0]  wdata_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [LINE_N-1:0] loop_lvl_o,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              out1_o,
    output logic              irq_en_o,
    output logic              loop_o
);
    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctl_q <= '0;
        else if (wr_i) ctl_q <= wdata_i;
    end

    assign loop_o   = ctl_q[CB_LOOP];
    assign dtr_o    = ctl_q[CB_DTR]  & ~ctl_q[CB_LOOP];
    assign rts_o    = ctl_q[CB_RTS]  & ~ctl_q[CB_LOOP];
    assign out1_o   = ctl_q[CB_OUT1] & ~ctl_q[CB_LOOP];
    assign irq_en_o = ctl_q[CB_IRQEN];

    // Internal crossover used in loopback mode.
    always_comb begin
        loop_lvl_o         = '0;
        loop_lvl_o[LN_CTS] = ctl_q[CB_RTS];
        loop_lvl_o[LN_DSR] = ctl_q[CB_DTR];
        loop_lvl_o[LN_RI]  = ctl_q[CB_OUT1];
        loop_lvl_o[LN_DCD] = ctl_q[CB_IRQEN];
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_N-1:0] lvl_i,
    input  logic              clr_i,
    output logic [LINE_N-1:0] delta_o,
    output logic [LINE_N-1:0] prev_o,
    output logic              settling_o
);
    localparam int SETTLE_CYC = SYNC_STAGES + 1;
    localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

    trk_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [LINE_N-1:0] prev_q;
    logic [LINE_N-1:0] delta_q;
    logic [LINE_N-1:0] set_v;
    logic              arm;

    // State register and settle counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE: if (cnt_q == CNT_W'(SETTLE_CYC - 1)) state_d = ST_TRACK;
            ST_TRACK:  state_d = ST_TRACK;
            default:   state_d = ST_SETTLE;
        endcase
    end

    // Outputs of the state machine: which changes may be recorded.
    always_comb begin
        arm           = (state_q == ST_TRACK);
        set_v         = '0;
        set_v[LN_CTS] = arm & (lvl_i[LN_CTS] ^ prev_q[LN_CTS]);
        set_v[LN_DSR] = arm & (lvl_i[LN_DSR] ^ prev_q[LN_DSR]);
        set_v[LN_RI]  = arm & prev_q[LN_RI] & ~lvl_i[LN_RI];
        set_v[LN_DCD] = arm & (lvl_i[LN_DCD] ^ prev_q[LN_DCD]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= lvl_i;
            delta_q <= (clr_i ? '0 : delta_q) | set_v;
        end
    end

    assign delta_o    = delta_q;
    assign prev_o     = prev_q;
    assign settling_o = (state_q == ST_SETTLE);
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       ri_i,
    input  logic       dcd_i,
    output logic       dtr_o,
    output logic       rts_o,
    output logic       out1_o,
    output logic       irq_en_o,
    output logic       msi_o
);
    logic [CTL_W-1:0]  ctl_q;
    logic [LINE_N-1:0] ext_raw, ext_sync, loop_lvl, lvl, lvl_prev, delta_q;
    logic              loop_on, settling, stat_rd, ctl_wr;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^host_wdata[7:CTL_W];
    assign ctl_wr  = host_wr & (host_addr == ADDR_CTL);
    assign stat_rd = host_rd & (host_addr == ADDR_STAT);

    always_comb begin
        ext_raw         = '0;
        ext_raw[LN_CTS] = cts_i;
        ext_raw[LN_DSR] = dsr_i;
        ext_raw[LN_RI]  = ri_i;
        ext_raw[LN_DCD] = dcd_i;
    end

    mdm_ctl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctl_wr),
        .wdata_i    (host_wdata[CTL_W-1:0]),
        .ctl_o      (ctl_q),
        .loop_lvl_o (loop_lvl),
        .dtr_o      (dtr_o),
        .rts_o      (rts_o),
        .out1_o     (out1_o),
        .irq_en_o   (irq_en_o),
        .loop_o     (loop_on)
    );

    mdm_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_raw),
        .sync_o  (ext_sync)
    );

    assign lvl = loop_on ? loop_lvl : ext_sync;

    mdm_delta #(.SYNC_STAGES(SYNC_STAGES)) u_delta (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl),
        .clr_i      (stat_rd),
        .delta_o    (delta_q),
        .prev_o     (lvl_prev),
        .settling_o (settling)
    );

    assign msi_o      = |delta_q;
    assign host_rdata = (host_addr == ADDR_STAT) ? {lvl, delta_q}
                                                 : {{(8-CTL_W){1'b0}}, ctl_q};
endmodule

// File: rtl/mdm_ctl_stat_chk.sv
module mdm_ctl_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_addr,
    input logic [4:0] host_wdata,
    input logic [4:0] ctl_q,
    input logic [3:0] lvl,
    input logic [3:0] lvl_prev,
    input logic [3:0] delta_q,
    input logic       settling,
    input logic       stat_rd,
    input logic       dtr_o,
    input logic       rts_o,
    input logic       out1_o,
    input logic       irq_en_o
);
    // R2: a non-loopback control write reaches the pins one cycle later.
    p_ctl_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_addr && !host_wdata[4]) |=>
            (dtr_o == $past(host_wdata[0]) && rts_o == $past(host_wdata[1]) &&
             out1_o == $past(host_wdata[2]) && irq_en_o == $past(host_wdata[3])));

    // R8: loopback keeps external handshake outputs quiet.
    p_loop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> (!dtr_o && !rts_o && !out1_o));

    // R5: the ring flag appears only after a falling ring level.
    p_ri_trail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(lvl_prev[2]) && !$past(lvl[2])));

    // R6: flags never drop without a status read.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_q != 4'b0 && !stat_rd) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R6: a read with no coincident change empties the flags.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && lvl == lvl_prev) |=> (delta_q == 4'b0));

    // R9: nothing is recorded while the synchronizers fill.
    p_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> (delta_q == 4'b0));
endmodule

bind mdm_ctl_stat mdm_ctl_stat_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata[4:0]),
    .ctl_q      (ctl_q),
    .lvl        (lvl),
    .lvl_prev   (lvl_prev),
    .delta_q    (delta_q),
    .settling   (settling),
    .stat_rd    (stat_rd),
    .dtr_o      (dtr_o),
    .rts_o      (rts_o),
    .out1_o     (out1_o),
    .irq_en_o   (irq_en_o)
);

// File: tb/mdm_ctl_stat_tb_top.sv
`timescale 1ns/1ps
module mdm_ctl_stat_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       cts_i = 1'b1, dsr_i = 1'b0, ri_i = 1'b0, dcd_i = 1'b0;
    logic       dtr_o, rts_o, out1_o, irq_en_o, msi_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Scoreboard queues: expected byte, source select (0 rdata, 1 pins), tag.
    logic [7:0] exp_q[$];
    bit         sel_q[$];
    string      tag_q[$];
    bit         probe_on = 1'b0;

    always #5 clk = ~clk;

    mdm_ctl_stat dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
        .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .irq_en_o(irq_en_o),
        .msi_o(msi_o)
    );

    // Monitor: compares observed values against queued expectations.
    always @(negedge clk) begin
        #2;
        if (probe_on && exp_q.size() > 0) begin
            logic [7:0] exp_v, got;
            bit         s;
            string      t;
            exp_v = exp_q.pop_front();
            s     = sel_q.pop_front();
            t     = tag_q.pop_front();
            got   = s ? {3'b000, msi_o, irq_en_o, out1_o, rts_o, dtr_o} : host_rdata;
            checks++;
            if (got !== exp_v) begin
                failures++;
                $display("FAIL %s actual=%02h expected=%02h", t, got, exp_v);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired, requirements R1 to R10 unfinished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr_ctl(input logic [7:0] d);
        host_addr = 1'b0; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic a, input logic [7:0] e, input string t);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); sel_q.push_back(1'b0); tag_q.push_back(t);
        probe_on = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; probe_on = 1'b0;
    endtask

    // Pin vector = {msi, irq_en, out1, rts, dtr}
    task automatic pins_exp(input logic [7:0] e, input string t);
        exp_q.push_back(e); sel_q.push_back(1'b1); tag_q.push_back(t);
        probe_on = 1'b1;
        @(negedge clk);
        probe_on = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(6);
        // R10 / R9 / R3: cts held high through reset gives a level and no flag
        rd_exp(1'b1, 8'h10, "R9 R3 status after reset");
        rd_exp(1'b0, 8'h00, "R10 control after reset");
        pins_exp(8'h00, "R10 pins after reset");

        wr_ctl(8'h0F);
        rd_exp(1'b0, 8'h0F, "R1 control readback");
        pins_exp(8'h0F, "R2 pins follow control");
        wr_ctl(8'hE5);
        rd_exp(1'b0, 8'h05, "R1 upper bits read zero");
        pins_exp(8'h05, "R2 pins after second write");
        wr_ctl(8'h00);

        dsr_i = 1'b1; idle(3);
        pins_exp(8'h10, "R7 interrupt cause raised");
        idle(5);
        rd_exp(1'b1, 8'h32, "R4 R6 dsr change held");
        rd_exp(1'b1, 8'h30, "R6 flags cleared by read");
        pins_exp(8'h00, "R7 interrupt cause dropped");

        ri_i = 1'b1; idle(3);
        rd_exp(1'b1, 8'h70, "R5 leading ring edge ignored");
        ri_i = 1'b0; idle(3);
        rd_exp(1'b1, 8'h34, "R5 trailing ring edge flagged");
        rd_exp(1'b1, 8'h30, "R6 ring flag cleared");

        dcd_i = 1'b1; cts_i = 1'b0; idle(3);
        rd_exp(1'b1, 8'hA9, "R4 cts and dcd changes");
        rd_exp(1'b1, 8'hA0, "R3 levels after clear");

        wr_ctl(8'h10); idle(2);
        rd_exp(1'b1, 8'h0A, "R8 entering loopback");
        pins_exp(8'h00, "R8 outputs quiet");
        wr_ctl(8'h17); idle(2);
        pins_exp(8'h10, "R8 outputs held inactive");
        rd_exp(1'b1, 8'h73, "R8 crossover levels");
        rd_exp(1'b1, 8'h70, "R8 levels after clear");

        dsr_i = 1'b0; dcd_i = 1'b0; ri_i = 1'b1; cts_i = 1'b1; idle(4);
        rd_exp(1'b1, 8'h70, "R8 external inputs ignored");

        wr_ctl(8'h13);
        rd_exp(1'b1, 8'h30, "R6 read during ring edge");
        rd_exp(1'b1, 8'h34, "R6 coincident flag kept");
        rd_exp(1'b1, 8'h30, "R6 cleared afterwards");

        wr_ctl(8'h18); idle(2);
        pins_exp(8'h18, "R2 R7 enable and cause");
        rd_exp(1'b1, 8'h8B, "R8 enable drives carrier detect");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule